// File: doc/BRIEF.md
# Oversampling Serial Receiver with Sleep and Address Wake-Up

This block receives asynchronous serial frames. A sample-rate enable pulses eight times per bit. After the line is resynchronised, a falling edge starts a frame. Each bit is settled by a two-of-three vote over the middle samples of that bit. The block then unpacks a programmable format into a receive buffer: 1 to 8 data bits, an optional address bit and optional even or odd parity. It reports parity, framing, overrun and break conditions, and drives an OR of the four as a summary error output.

Several receivers can share one line. Each can be put to sleep, and while asleep it accepts only address frames. An address frame is recognised in one of two ways. In idle-gap mode, the line was quiet for at least ten bit times before the start edge. In address-bit mode, the frame's extra bit is 1. A wake flag tells the host whether the last accepted character was an address frame.

Top module: `sleepy_rx`

## Requirements
- R1: A frame begins on the first sample-rate pulse at which the synchronised line is low after being high at the previous pulse. Each bit lasts 8 pulses. Data bits arrive LSB first, their number is `dataLenM1`+1, and unused upper bits of `rxData` read 0.
- R2: Each bit takes the majority of its 4th, 5th and 6th samples. A start bit whose vote is high is dropped, so no frame is received.
- R3: Frame order is start, data, address bit (only when `addrBitMode`=1), parity (only when `parityEn`=1), stop. Parity is checked over the data bits, the address bit and the parity bit. The total count of ones must be even when `parityEven`=1 and odd when it is 0. On a mismatch, `parityErr` is set when the character is accepted.
- R4: When a character is accepted, `rxData` updates and `rxReady` rises. A one-cycle `rdStrobe` clears `rxReady`.
- R5: With `sleepEn`=1, a frame that is not an address frame is discarded. `rxReady`, `rxData` and the flags stay unchanged.
- R6: In idle-gap mode (`addrBitMode`=0), a frame is an address frame when at least 80 consecutive high samples (10 bit times) came right before its start edge.
- R7: In address-bit mode, a frame is an address frame exactly when its address bit is 1, whatever the idle time before it.
- R8: `wakeDet` shows whether the most recently accepted character was an address frame.
- R9: `frameErr` is set when an accepted character's stop bit votes low.
- R10: `overrunErr` is set when a character is accepted while `rxReady` is still 1 and no read happens in that cycle. The new data replaces the old.
- R11: `breakDet` is set when, after a low stop-bit vote, the line stays low for 80 more samples. It is not set if the line returns high before that.
- R12: `rxError` is the OR of the four error flags. The flags stay set until `swReset`, which clears them together with `rxReady` and `wakeDet`.
- R13: After reset, `rxReady`, `wakeDet`, every error flag and `rxData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Sample enable, 8 per bit |
| rxLine | input | 1 | Serial receive line, idle high |
| dataLenM1 | input | 3 | Data bit count minus one |
| parityEn | input | 1 | Parity bit present |
| parityEven | input | 1 | 1 = even parity, 0 = odd |
| addrBitMode | input | 1 | 1 = address-bit mode, 0 = idle-gap mode |
| sleepEn | input | 1 | Accept only address frames |
| rdStrobe | input | 1 | Host read of the buffer, clears ready |
| swReset | input | 1 | Clears ready, wake and error flags |
| rxData | output | 8 | Received character |
| rxReady | output | 1 | New character available |
| wakeDet | output | 1 | Last accepted character was an address frame |
| parityErr | output | 1 | Parity error flag |
| frameErr | output | 1 | Framing error flag |
| overrunErr | output | 1 | Overrun error flag |
| breakDet | output | 1 | Break detected flag |
| rxError | output | 1 | OR of the error flags |

## Verification
A character is accepted on the 6th sample pulse of its stop bit. The line passes through two synchroniser flops first, and the buffer and flags register one clock after that pulse. The bench therefore checks results only after the whole stop bit (8 pulses) has been driven, which leaves at least two pulses of margin.

A break flag is due 80 pulses after the stop-bit decision, and the bench holds the line low for 11 further bit times before it looks. Reads and soft resets act on the next clock edge, so the bench checks them one clock later, away from the edge.

// File: rtl/sleepy_rx_pkg.sv
package sleepy_rx_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_ADDR, ST_PAR, ST_STOP, ST_BRK, ST_HOLD
  } rxState_t;

  typedef struct packed {
    logic             startSeen;
    logic             sampA;
    logic             sampB;
    logic             storeData;
    logic             storeAddr;
    logic             storePar;
    logic             frameDone;
    logic             breakHit;
    logic [IDX_W-1:0] bitIdx;
  } rxStrobe_t;
endpackage

// File: rtl/sleepy_rx_ctrl.sv
module sleepy_rx_ctrl
  import sleepy_rx_pkg::*;
#(
  parameter int OVS        = 8,
  parameter int BREAK_BITS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             lineS,
  input  logic             fallEdge,
  input  logic             vote,
  input  logic [IDX_W-1:0] dataLenM1,
  input  logic             addrBitMode,
  input  logic             parityEn,
  output rxStrobe_t        strobe
);
  localparam int PH_W        = $clog2(OVS);
  localparam int BREAK_TICKS = BREAK_BITS * OVS;
  localparam int BRK_W       = $clog2(BREAK_TICKS);
  localparam logic [PH_W-1:0] PH_A    = PH_W'(OVS/2 - 1);
  localparam logic [PH_W-1:0] PH_B    = PH_W'(OVS/2);
  localparam logic [PH_W-1:0] PH_VOTE = PH_W'(OVS/2 + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  rxState_t         state, stateNxt;
  logic [PH_W-1:0]  phase, phaseNxt;
  logic [IDX_W-1:0] bitIdx, bitIdxNxt;
  logic [BRK_W-1:0] brkCnt, brkCntNxt;

  always_comb begin
    stateNxt  = state;
    phaseNxt  = phase;
    bitIdxNxt = bitIdx;
    brkCntNxt = brkCnt;
    strobe    = '0;
    strobe.bitIdx = bitIdx;
    if (sampleTick) begin
      unique case (state)
        ST_IDLE: if (fallEdge) begin
          stateNxt = ST_START;
          phaseNxt = PH_W'(1);
          strobe.startSeen = 1'b1;
        end
        ST_BRK: begin
          if (lineS) stateNxt = ST_IDLE;
          else if (brkCnt == BRK_W'(BREAK_TICKS - 1)) begin
            strobe.breakHit = 1'b1;
            stateNxt = ST_HOLD;
          end else brkCntNxt = brkCnt + 1'b1;
        end
        ST_HOLD: if (lineS) stateNxt = ST_IDLE;
        default: begin
          phaseNxt = (phase == PH_LAST) ? '0 : phase + 1'b1;
          strobe.sampA = (phase == PH_A);
          strobe.sampB = (phase == PH_B);
          if (phase == PH_VOTE) begin
            unique case (state)
              ST_START: if (vote) stateNxt = ST_IDLE;
              ST_DATA:  strobe.storeData = 1'b1;
              ST_ADDR:  strobe.storeAddr = 1'b1;
              ST_PAR:   strobe.storePar  = 1'b1;
              ST_STOP: begin
                strobe.frameDone = 1'b1;
                stateNxt  = vote ? ST_IDLE : ST_BRK;
                brkCntNxt = '0;
              end
              default: ;
            endcase
          end
          if (phase == PH_LAST) begin
            unique case (state)
              ST_START: begin
                stateNxt  = ST_DATA;
                bitIdxNxt = '0;
              end
              ST_DATA: begin
                if (bitIdx == dataLenM1)
                  stateNxt = addrBitMode ? ST_ADDR : (parityEn ? ST_PAR : ST_STOP);
                else bitIdxNxt = bitIdx + 1'b1;
              end
              ST_ADDR: stateNxt = parityEn ? ST_PAR : ST_STOP;
              ST_PAR:  stateNxt = ST_STOP;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitIdx <= '0;
      brkCnt <= '0;
    end else begin
      state  <= stateNxt;
      phase  <= phaseNxt;
      bitIdx <= bitIdxNxt;
      brkCnt <= brkCntNxt;
    end
  end

  AST_ONE_STORE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.storeData, strobe.storeAddr, strobe.storePar, strobe.frameDone})); // R3
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.breakHit |-> !lineS); // R11
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startSeen |=> (state == ST_START)); // R1
endmodule

// File: rtl/sleepy_rx_dp.sv
module sleepy_rx_dp
  import sleepy_rx_pkg::*;
#(
  parameter int OVS       = 8,
  parameter int IDLE_BITS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  rxStrobe_t  strobe,
  input  logic       parityEven,
  input  logic       parityEn,
  input  logic       addrBitMode,
  input  logic       sleepEn,
  input  logic       rdStrobe,
  input  logic       swReset,
  output logic       lineS,
  output logic       fallEdge,
  output logic       vote,
  output logic [7:0] rxData,
  output logic       rxReady,
  output logic       wakeDet,
  output logic       parityErr,
  output logic       frameErr,
  output logic       overrunErr,
  output logic       breakDet,
  output logic       rxError
);
  localparam int IDLE_TICKS = IDLE_BITS * OVS;
  localparam int IDLE_W     = $clog2(IDLE_TICKS + 1);

  logic              syncA, prevS, smpA, smpB, idleLong, addrBitReg, parBitReg;
  logic [IDLE_W-1:0] idleCnt;
  logic [7:0]        shiftReg;
  logic              isAddr, loadOk, parBad;

  assign fallEdge = sampleTick && prevS && !lineS;
  assign vote     = (smpA & smpB) | (smpA & lineS) | (smpB & lineS);
  assign isAddr   = addrBitMode ? addrBitReg : idleLong;
  assign loadOk   = strobe.frameDone && (!sleepEn || isAddr);
  assign parBad   = parityEn && ((^{shiftReg, addrBitReg & addrBitMode, parBitReg & parityEn}) ^ ~parityEven);
  assign rxError  = parityErr | frameErr | overrunErr | breakDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA      <= 1'b0;
      lineS      <= 1'b0;
      prevS      <= 1'b0;
      idleCnt    <= '0;
      idleLong   <= 1'b0;
      smpA       <= 1'b0;
      smpB       <= 1'b0;
      shiftReg   <= '0;
      addrBitReg <= 1'b0;
      parBitReg  <= 1'b0;
    end else begin
      syncA <= rxLine;
      lineS <= syncA;
      if (sampleTick) begin
        prevS <= lineS;
        if (!lineS) idleCnt <= '0;
        else if (idleCnt != IDLE_W'(IDLE_TICKS)) idleCnt <= idleCnt + 1'b1;
      end
      if (strobe.startSeen) begin
        idleLong   <= (idleCnt >= IDLE_W'(IDLE_TICKS));
        shiftReg   <= '0;
        addrBitReg <= 1'b0;
        parBitReg  <= 1'b0;
      end
      if (strobe.sampA)     smpA <= lineS;
      if (strobe.sampB)     smpB <= lineS;
      if (strobe.storeData) shiftReg[strobe.bitIdx] <= vote;
      if (strobe.storeAddr) addrBitReg <= vote;
      if (strobe.storePar)  parBitReg <= vote;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxReady    <= 1'b0;
      wakeDet    <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
      breakDet   <= 1'b0;
    end else if (swReset) begin
      rxReady    <= 1'b0;
      wakeDet    <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
      breakDet   <= 1'b0;
    end else begin
      if (loadOk) begin
        rxData  <= shiftReg;
        rxReady <= 1'b1;
        wakeDet <= isAddr;
        if (!vote) frameErr <= 1'b1;
        if (parBad) parityErr <= 1'b1;
        if (rxReady && !rdStrobe) overrunErr <= 1'b1;
      end else if (rdStrobe) begin
        rxReady <= 1'b0;
      end
      if (strobe.breakHit) breakDet <= 1'b1;
    end
  end

  AST_LOAD_SETS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (loadOk && !swReset) |=> rxReady); // R4
  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && sleepEn && !isAddr && !rxReady && !swReset && !rdStrobe) |=> !rxReady); // R5
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (loadOk && rxReady && !rdStrobe && !swReset) |=> overrunErr); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rxError && !swReset) |=> rxError); // R12
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (!rxReady && !rxError && !wakeDet)); // R12
endmodule

// File: rtl/sleepy_rx.sv
module sleepy_rx
  import sleepy_rx_pkg::*;
#(
  parameter int OVS        = 8,
  parameter int IDLE_BITS  = 10,
  parameter int BREAK_BITS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic [2:0] dataLenM1,
  input  logic       parityEn,
  input  logic       parityEven,
  input  logic       addrBitMode,
  input  logic       sleepEn,
  input  logic       rdStrobe,
  input  logic       swReset,
  output logic [7:0] rxData,
  output logic       rxReady,
  output logic       wakeDet,
  output logic       parityErr,
  output logic       frameErr,
  output logic       overrunErr,
  output logic       breakDet,
  output logic       rxError
);
  rxStrobe_t strobe;
  logic      lineS, fallEdge, vote;

  sleepy_rx_ctrl #(.OVS(OVS), .BREAK_BITS(BREAK_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .lineS(lineS),
    .fallEdge(fallEdge), .vote(vote), .dataLenM1(dataLenM1),
    .addrBitMode(addrBitMode), .parityEn(parityEn), .strobe(strobe)
  );

  sleepy_rx_dp #(.OVS(OVS), .IDLE_BITS(IDLE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .strobe(strobe), .parityEven(parityEven), .parityEn(parityEn),
    .addrBitMode(addrBitMode), .sleepEn(sleepEn), .rdStrobe(rdStrobe),
    .swReset(swReset), .lineS(lineS), .fallEdge(fallEdge), .vote(vote),
    .rxData(rxData), .rxReady(rxReady), .wakeDet(wakeDet),
    .parityErr(parityErr), .frameErr(frameErr), .overrunErr(overrunErr),
    .breakDet(breakDet), .rxError(rxError)
  );
endmodule

// File: tb/sim_sleepy_rx.sv
module sim_sleepy_rx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxLine = 1'b1;
  logic [2:0] dataLenM1 = 3'd7;
  logic       parityEn = 1'b0;
  logic       parityEven = 1'b0;
  logic       addrBitMode = 1'b0;
  logic       sleepEn = 1'b0;
  logic       rdStrobe = 1'b0;
  logic       swReset = 1'b0;
  logic [7:0] rxData;
  logic       rxReady, wakeDet, parityErr, frameErr, overrunErr, breakDet, rxError;
  logic [1:0] tickCnt = '0;
  int         nChecks = 0;
  int         nFails = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tickCnt    <= tickCnt + 1'b1;
    sampleTick <= (tickCnt == 2'd3);
  end

  sleepy_rx u0 (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .dataLenM1(dataLenM1), .parityEn(parityEn), .parityEven(parityEven),
    .addrBitMode(addrBitMode), .sleepEn(sleepEn), .rdStrobe(rdStrobe),
    .swReset(swReset), .rxData(rxData), .rxReady(rxReady), .wakeDet(wakeDet),
    .parityErr(parityErr), .frameErr(frameErr), .overrunErr(overrunErr),
    .breakDet(breakDet), .rxError(rxError)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic lineBits(input bit v, input int nBits);
    rxLine = v;
    repeat (nBits * 32) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit aBit, input bit badPar, input bit stopVal);
    int ones = 0;
    bit pBit;
    lineBits(1'b0, 1);
    for (int i = 0; i <= int'(dataLenM1); i++) begin
      lineBits(d[i], 1);
      ones += d[i];
    end
    if (addrBitMode) begin
      lineBits(aBit, 1);
      ones += aBit;
    end
    if (parityEn) begin
      pBit = parityEven ? ones[0] : ~ones[0];
      lineBits(pBit ^ badPar, 1);
    end
    lineBits(stopVal, 1);
  endtask

  task automatic doRead();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic doSoftReset();
    swReset = 1'b1;
    @(negedge clk);
    swReset = 1'b0;
    @(negedge clk);
  endtask

  task automatic testResetState();
    check("R13 ready", rxReady, 0);
    check("R13 data", rxData, 0);
    check("R13 error", rxError, 0);
    check("R13 wake", wakeDet, 0);
  endtask

  task automatic testBasic();
    lineBits(1'b1, 12);
    sendFrame(8'hA5, 1'b0, 1'b0, 1'b1);
    check("R1 data", rxData, 8'hA5);
    check("R4 ready set", rxReady, 1);
    check("R9 no frame err", frameErr, 0);
    doRead();
    check("R4 ready cleared by read", rxReady, 0);
  endtask

  task automatic testParity();
    dataLenM1 = 3'd4; parityEn = 1'b1; parityEven = 1'b1;
    lineBits(1'b1, 2);
    sendFrame(8'h1B, 1'b0, 1'b0, 1'b1);
    check("R1 five-bit data", rxData, 8'h1B);
    check("R3 good even parity", parityErr, 0);
    doRead();
    dataLenM1 = 3'd6; parityEven = 1'b0;
    lineBits(1'b1, 2);
    sendFrame(8'h55, 1'b0, 1'b1, 1'b1);
    check("R1 seven-bit data", rxData, 8'h55);
    check("R3 bad odd parity", parityErr, 1);
    check("R12 summary", rxError, 1);
    doSoftReset();
    check("R12 soft reset flags", rxError, 0);
    check("R12 soft reset ready", rxReady, 0);
    dataLenM1 = 3'd7; parityEn = 1'b0;
  endtask

  task automatic testGlitch();
    lineBits(1'b1, 2);
    rxLine = 1'b0;
    repeat (8) @(negedge clk);
    lineBits(1'b1, 3);
    check("R2 glitch rejected ready", rxReady, 0);
    check("R2 glitch no error", rxError, 0);
  endtask

  task automatic testOverrun();
    lineBits(1'b1, 2);
    sendFrame(8'h11, 1'b0, 1'b0, 1'b1);
    lineBits(1'b1, 1);
    check("R10 no overrun yet", overrunErr, 0);
    sendFrame(8'h22, 1'b0, 1'b0, 1'b1);
    check("R10 overrun", overrunErr, 1);
    check("R10 newest data", rxData, 8'h22);
    check("R12 summary overrun", rxError, 1);
    doSoftReset();
  endtask

  task automatic testFraming();
    lineBits(1'b1, 2);
    sendFrame(8'h3C, 1'b0, 1'b0, 1'b0);
    lineBits(1'b1, 12);
    check("R9 framing", frameErr, 1);
    check("R9 data kept", rxData, 8'h3C);
    check("R11 short low no break", breakDet, 0);
    doSoftReset();
  endtask

  task automatic testBreak();
    lineBits(1'b1, 2);
    sendFrame(8'h00, 1'b0, 1'b0, 1'b0);
    lineBits(1'b0, 11);
    check("R11 break", breakDet, 1);
    check("R9 framing with break", frameErr, 1);
    lineBits(1'b1, 2);
    doSoftReset();
    check("R12 break cleared", breakDet, 0);
  endtask

  task automatic testSleepIdle();
    sleepEn = 1'b1; addrBitMode = 1'b0;
    lineBits(1'b1, 12);
    sendFrame(8'h31, 1'b0, 1'b0, 1'b1);
    check("R6 address after long idle", rxReady, 1);
    check("R6 address data", rxData, 8'h31);
    check("R8 wake set", wakeDet, 1);
    doRead();
    lineBits(1'b1, 2);
    sendFrame(8'h55, 1'b0, 1'b0, 1'b1);
    check("R5 data frame discarded ready", rxReady, 0);
    check("R5 data unchanged", rxData, 8'h31);
  endtask

  task automatic testSleepAddrBit();
    addrBitMode = 1'b1;
    lineBits(1'b1, 12);
    sendFrame(8'h44, 1'b0, 1'b0, 1'b1);
    check("R7 long idle ignored", rxReady, 0);
    check("R5 data unchanged abit", rxData, 8'h31);
    lineBits(1'b1, 1);
    sendFrame(8'h66, 1'b1, 1'b0, 1'b1);
    check("R7 address bit wakes", rxReady, 1);
    check("R7 address data", rxData, 8'h66);
    check("R8 wake abit", wakeDet, 1);
    doRead();
    sleepEn = 1'b0;
    lineBits(1'b1, 1);
    sendFrame(8'h77, 1'b0, 1'b0, 1'b1);
    check("R4 awake data", rxData, 8'h77);
    check("R8 wake cleared on data frame", wakeDet, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testBasic();
    testParity();
    testGlitch();
    testOverrun();
    testFraming();
    testBreak();
    testSleepIdle();
    testSleepAddrBit();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule